// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a single multiple-register load or store command into a stream of single-word memory requests. A command carries a 16-bit register mask, a base address, the index of the register that holds that base, a 2-bit addressing mode, a load/store select, a writeback flag and a user-bank flag. The command also carries the current program counter and status word, which are used when the program counter register is stored.

Once the block has accepted a command, it issues one request per valid/ready handshake. Each request carries a word address and the index of the register to move. Registers are always visited from the lowest index to the highest, and addresses always rise by 4, whatever the direction of the mode. On stores, the block marks requests whose data must come from somewhere other than the register file, and it supplies that data. When the command finishes, a one-cycle completion pulse carries the updated base value, a writeback enable and a status-restore request.

A memory port and a register file sit on either side of the block. It holds no data memory of its own.

Top module: `blk_xfer_seq`

## Requirements
- R1: Requests follow the set bits of the register mask, one request per handshake, with `req_reg` rising strictly from the lowest set index to the highest.
- R2: `cmd_mode` encoding: 2'b01 increment-after (first address = base), 2'b11 increment-before (base+4), 2'b00 decrement-after (base−4·n+4), 2'b10 decrement-before (base−4·n), where n is the number of set bits. Each later request's address is 4 above the previous one.
- R3: At completion, `wb_value` is base+4·n for the increment modes and base−4·n for the decrement modes. `wb_en` is high only when `cmd_wb` was set.
- R4: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_reg` and the other request fields hold their values.
- R5: When `cmd_base_idx` is 15, `wb_en` stays low even if `cmd_wb` is set.
- R6: On a store, the request for the base register has `req_sub_valid`=1. `req_sub_data` is the original base when the base is the lowest set register in the mask or writeback is off. Otherwise it is the updated base.
- R7: On a store, the request for register 15 has `req_sub_valid`=1 and `req_sub_data` = ((pc+12) & 32'h03FF_FFFC) | (psr & 32'hFC00_0003). This rule takes precedence over R6.
- R8: When a load includes register 15 and `cmd_user` is set, `psr_restore` is high during the completion pulse and `req_user_bank` stays low. Otherwise, `req_user_bank` equals `cmd_user` on every request and `psr_restore` stays low.
- R9: `done` is high for exactly one cycle, in the cycle after the last handshake. `cmd_ready` is high only when the block is idle, and a command is accepted only then.
- R10: An empty register mask produces no request. `done` rises in the cycle after acceptance, with `wb_value` equal to the base.
- R11: Loads drive `req_write`=0 and `req_sub_valid`=0. Stores drive `req_write`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept |
| cmd_reglist | input | 16 | Register mask, bit i selects register i |
| cmd_base | input | 32 | Base address value |
| cmd_base_idx | input | 4 | Index of the base register |
| cmd_mode | input | 2 | Addressing mode (see R2) |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Write the updated base back |
| cmd_user | input | 1 | User-bank / status-restore flag |
| cmd_pc | input | 32 | Program counter of the command |
| cmd_psr | input | 32 | Status word merged into a stored register 15 |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | 32 | Word address |
| req_reg | output | 4 | Register index moved |
| req_write | output | 1 | 1 = store |
| req_user_bank | output | 1 | Use user-mode register bank |
| req_sub_valid | output | 1 | Store data comes from req_sub_data |
| req_sub_data | output | 32 | Substitute store data |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Write wb_value to the base register |
| wb_value | output | 32 | Updated base |
| psr_restore | output | 1 | Restore the status word from the saved copy |

## Verification
The embedded properties assume that `req_ready` is driven from a register and never depends on the same cycle's `req_valid`. They also assume that `cmd_valid` is offered only while `cmd_ready` is high, so a command never waits across a busy period. The bench follows both rules: it drives every input at the falling edge and starts a new command only after the previous one has finished. The random masks, bases, base indices, modes and flags stay within their field widths. Stalls come from a random ready pattern. Directed commands cover the empty mask, a base register of 15, a base register that is lowest or not lowest in the mask, a stored register 15, and a user-flag load that includes register 15.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
    localparam int NREG  = 16;
    localparam int AW    = 32;
    localparam int IDXW  = $clog2(NREG);
    localparam int CNTW  = $clog2(NREG + 1);
    localparam int WORD_BYTES = 4;

    localparam logic [AW-1:0] PC_FIELD_MASK   = 32'h03FF_FFFC;
    localparam logic [AW-1:0] PC_STORE_OFFSET = 32'd12;

    // bit1 = adjust before transfer, bit0 = ascending
    typedef enum logic [1:0] {
        AM_DEC_AFTER  = 2'b00,
        AM_INC_AFTER  = 2'b01,
        AM_DEC_BEFORE = 2'b10,
        AM_INC_BEFORE = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] start_addr;
        logic [AW-1:0] new_base;
        logic [AW-1:0] pc_word;
        logic          wb_en;
        logic          psr_restore;
        logic          user_bank;
        logic          base_first;
        logic          empty;
    } xfer_plan_t;

    function automatic logic [CNTW-1:0] mask_pop(input logic [NREG-1:0] m);
        logic [CNTW-1:0] c;
        c = '0;
        for (int i = 0; i < NREG; i++) c = c + CNTW'(m[i]);
        return c;
    endfunction
endpackage

// File: rtl/bxs_planner.sv
module bxs_planner
    import bxs_pkg::*;
(
    input  logic [NREG-1:0] reglist,
    input  logic [AW-1:0]   base,
    input  logic [IDXW-1:0] base_idx,
    input  addr_mode_e      mode,
    input  logic            load,
    input  logic            wb,
    input  logic            user,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   psr,
    output xfer_plan_t      plan
);
    localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

    logic [CNTW-1:0] cnt;
    logic [AW-1:0]   span;
    logic [NREG-1:0] below_base;
    logic            pc_in_list;

    always_comb begin
        cnt  = mask_pop(reglist);
        span = AW'(cnt) * AW'(WORD_BYTES);
        for (int i = 0; i < NREG; i++) below_base[i] = (IDXW'(i) < base_idx);
        pc_in_list = reglist[NREG-1];

        unique case (mode)
            AM_INC_AFTER:  plan.start_addr = base;
            AM_INC_BEFORE: plan.start_addr = base + AW'(WORD_BYTES);
            AM_DEC_AFTER:  plan.start_addr = base - span + AW'(WORD_BYTES);
            default:       plan.start_addr = base - span;
        endcase
        plan.new_base    = mode[0] ? (base + span) : (base - span);
        plan.pc_word     = ((pc + PC_STORE_OFFSET) & PC_FIELD_MASK) | (psr & ~PC_FIELD_MASK);
        plan.wb_en       = wb && (base_idx != PC_IDX);
        plan.psr_restore = user && load && pc_in_list;
        plan.user_bank   = user && !(load && pc_in_list);
        plan.base_first  = reglist[base_idx] && ((reglist & below_base) == '0);
        plan.empty       = (reglist == '0);
    end
endmodule

// File: rtl/bxs_picker.sv
module bxs_picker
    import bxs_pkg::*;
(
    input  logic [NREG-1:0] mask,
    output logic [IDXW-1:0] idx,
    output logic [NREG-1:0] rest,
    output logic            last
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDXW'(i);
        end
        rest = mask & (mask - NREG'(1));
        last = (rest == '0);
    end
endmodule

// File: rtl/bxs_store_src.sv
module bxs_store_src
    import bxs_pkg::*;
(
    input  logic [IDXW-1:0] reg_idx,
    input  logic            is_store,
    input  logic [IDXW-1:0] base_idx,
    input  logic            base_first,
    input  logic            wb_en,
    input  logic [AW-1:0]   orig_base,
    input  logic [AW-1:0]   new_base,
    input  logic [AW-1:0]   pc_word,
    output logic            sub_valid,
    output logic [AW-1:0]   sub_data
);
    localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

    always_comb begin
        sub_valid = 1'b0;
        sub_data  = '0;
        if (is_store) begin
            if (reg_idx == PC_IDX) begin
                sub_valid = 1'b1;
                sub_data  = pc_word;
            end else if (reg_idx == base_idx) begin
                sub_valid = 1'b1;
                sub_data  = (base_first || !wb_en) ? orig_base : new_base;
            end
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import bxs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [15:0]   cmd_reglist,
    input  logic [31:0]   cmd_base,
    input  logic [3:0]    cmd_base_idx,
    input  logic [1:0]    cmd_mode,
    input  logic          cmd_load,
    input  logic          cmd_wb,
    input  logic          cmd_user,
    input  logic [31:0]   cmd_pc,
    input  logic [31:0]   cmd_psr,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [31:0]   req_addr,
    output logic [3:0]    req_reg,
    output logic          req_write,
    output logic          req_user_bank,
    output logic          req_sub_valid,
    output logic [31:0]   req_sub_data,
    output logic          done,
    output logic          wb_en,
    output logic [31:0]   wb_value,
    output logic          psr_restore
);
    seq_state_e      state_q;
    xfer_plan_t      plan, plan_q;
    logic [NREG-1:0] mask_q, rest;
    logic [AW-1:0]   addr_q, base_q;
    logic [IDXW-1:0] bidx_q, pick_idx;
    logic            store_q, last;

    bxs_planner u_plan (
        .reglist(cmd_reglist), .base(cmd_base), .base_idx(cmd_base_idx),
        .mode(addr_mode_e'(cmd_mode)), .load(cmd_load), .wb(cmd_wb),
        .user(cmd_user), .pc(cmd_pc), .psr(cmd_psr), .plan(plan)
    );

    bxs_picker u_pick (.mask(mask_q), .idx(pick_idx), .rest(rest), .last(last));

    bxs_store_src u_src (
        .reg_idx(pick_idx), .is_store(store_q), .base_idx(bidx_q),
        .base_first(plan_q.base_first), .wb_en(plan_q.wb_en),
        .orig_base(base_q), .new_base(plan_q.new_base), .pc_word(plan_q.pc_word),
        .sub_valid(req_sub_valid), .sub_data(req_sub_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            base_q  <= '0;
            bidx_q  <= '0;
            store_q <= 1'b0;
            plan_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    mask_q  <= cmd_reglist;
                    addr_q  <= plan.start_addr;
                    base_q  <= cmd_base;
                    bidx_q  <= cmd_base_idx;
                    store_q <= !cmd_load;
                    plan_q  <= plan;
                    state_q <= plan.empty ? ST_DONE : ST_BUSY;
                end
                ST_BUSY: if (req_ready) begin
                    mask_q <= rest;
                    addr_q <= addr_q + AW'(WORD_BYTES);
                    if (last) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready     = (state_q == ST_IDLE);
    assign req_valid     = (state_q == ST_BUSY);
    assign req_addr      = addr_q;
    assign req_reg       = pick_idx;
    assign req_write     = store_q;
    assign req_user_bank = req_valid && plan_q.user_bank;
    assign done          = (state_q == ST_DONE);
    assign wb_en         = done && plan_q.wb_en;
    assign wb_value      = plan_q.new_base;
    assign psr_restore   = done && plan_q.psr_restore;

    // R4: request held while stalled
    a_r4_hold_stall: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg));
    // R2: addresses climb by one word
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !last |=> req_valid && (req_addr == $past(req_addr) + 32'd4));
    // R1: register index strictly rising
    a_r1_reg_rising: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_valid || (req_reg > $past(req_reg)));
    // R9: single-cycle completion, then idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && cmd_ready);
    // R9: last handshake leads to done
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && last |=> done);
    // R5: no writeback of register 15 base
    a_r5_no_pc_wb: assert property (@(posedge clk) disable iff (rst)
        done && (bidx_q == 4'd15) |-> !wb_en);
    // R11: loads never substitute
    a_r11_load_nosub: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_write |-> !req_sub_valid);
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        cmd_valid = 0, cmd_ready;
    logic [15:0] cmd_reglist = 0;
    logic [31:0] cmd_base = 0, cmd_pc = 0, cmd_psr = 0;
    logic [3:0]  cmd_base_idx = 0;
    logic [1:0]  cmd_mode = 0;
    logic        cmd_load = 0, cmd_wb = 0, cmd_user = 0;
    logic        req_valid, req_ready = 0;
    logic [31:0] req_addr, req_sub_data, wb_value;
    logic [3:0]  req_reg;
    logic        req_write, req_user_bank, req_sub_valid, done, wb_en, psr_restore;

    blk_xfer_seq dut_i (.*);

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int stall_pct = 35;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R9: actual hung expected completion");
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += m[i];
        return c;
    endfunction

    function automatic logic [31:0] exp_start(input logic [31:0] b, input logic [1:0] md, input int n);
        case (md)
            2'b01: return b;
            2'b11: return b + 4;
            2'b00: return b - 32'(4 * n) + 4;
            default: return b - 32'(4 * n);
        endcase
    endfunction

    function automatic logic [31:0] exp_new(input logic [31:0] b, input logic [1:0] md, input int n);
        return md[0] ? b + 32'(4 * n) : b - 32'(4 * n);
    endfunction

    task automatic run_cmd(input logic [15:0] rl, input logic [31:0] b, input logic [3:0] bi,
                           input logic [1:0] md, input bit ld, input bit w, input bit us,
                           input logic [31:0] pc, input logic [31:0] psr);
        int n, k, lowest;
        int idx[16];
        bit ended, rdy, was_v, exp_wb, exp_psr, exp_ub, base_low;
        logic [31:0] st, nb, pcw;
        n = 0;
        for (int i = 0; i < 16; i++) if (rl[i]) begin idx[n] = i; n++; end
        lowest  = (n > 0) ? idx[0] : -1;
        st      = exp_start(b, md, n);
        nb      = exp_new(b, md, n);
        exp_wb  = w && (bi != 4'd15);
        exp_psr = us && ld && rl[15];
        exp_ub  = us && !(ld && rl[15]);
        base_low = (lowest == int'(bi));
        pcw     = ((pc + 32'd12) & 32'h03FF_FFFC) | (psr & 32'hFC00_0003);

        @(negedge clk);
        chk(cmd_ready === 1'b1, "R9 idle ready", 64'(cmd_ready), 64'd1);
        cmd_valid = 1; cmd_reglist = rl; cmd_base = b; cmd_base_idx = bi;
        cmd_mode = md; cmd_load = ld; cmd_wb = w; cmd_user = us; cmd_pc = pc; cmd_psr = psr;
        @(negedge clk);
        cmd_valid = 0;
        k = 0; ended = 0;
        for (int cyc = 0; cyc < 400 && !ended; cyc++) begin
            if (done) begin
                ended = 1;
                chk(k == n, "R1/R10 transfer count", 64'(k), 64'(n));
                chk(wb_en === exp_wb, "R3/R5 wb_en", 64'(wb_en), 64'(exp_wb));
                if (exp_wb) chk(wb_value === nb, "R3 wb_value", 64'(wb_value), 64'(nb));
                if (n == 0) chk(wb_value === b && cyc == 0, "R10 empty done", 64'(wb_value), 64'(b));
                chk(psr_restore === exp_psr, "R8 psr_restore", 64'(psr_restore), 64'(exp_psr));
            end else begin
                was_v = req_valid;
                if (req_valid) begin
                    chk(cmd_ready === 1'b0, "R9 busy not ready", 64'(cmd_ready), 64'd0);
                    if (k < n) begin
                        chk(req_reg === 4'(idx[k]), "R1 reg order", 64'(req_reg), 64'(idx[k]));
                        chk(req_addr === st + 32'(4 * k), "R2 address", 64'(req_addr), 64'(st + 32'(4 * k)));
                        chk(req_write === !ld, "R11 write", 64'(req_write), 64'(!ld));
                        chk(req_user_bank === exp_ub, "R8 user bank", 64'(req_user_bank), 64'(exp_ub));
                        if (!ld && idx[k] == 15) begin
                            chk(req_sub_valid && req_sub_data === pcw, "R7 pc store",
                                {31'd0, req_sub_valid, req_sub_data}, {32'd1, pcw});
                        end else if (!ld && idx[k] == int'(bi)) begin
                            chk(req_sub_valid && req_sub_data === ((base_low || !exp_wb) ? b : nb),
                                "R6 base store", {31'd0, req_sub_valid, req_sub_data},
                                {32'd1, ((base_low || !exp_wb) ? b : nb)});
                        end else begin
                            chk(req_sub_valid === 1'b0, "R6/R11 no substitute", 64'(req_sub_valid), 64'd0);
                        end
                    end else begin
                        chk(0, "R1 extra request", 64'(k), 64'(n));
                    end
                end
                rdy = ($urandom_range(99) >= stall_pct);
                req_ready = rdy;
                @(negedge clk);
                if (was_v && rdy) k++;
            end
        end
        req_ready = 0;
        if (!ended) chk(0, "R9 done missing", 64'(k), 64'(n));
        @(negedge clk);
        chk(done === 1'b0 && cmd_ready === 1'b1, "R9 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready === 1 && req_valid === 0 && done === 0, "R9 reset state",
            {cmd_ready, req_valid, done}, 64'b100);
        // R2 each mode
        run_cmd(16'h00F0, 32'h1000, 4'd2, 2'b01, 1, 1, 0, 0, 0);
        run_cmd(16'h00F0, 32'h1000, 4'd2, 2'b11, 1, 1, 0, 0, 0);
        run_cmd(16'h00F0, 32'h1000, 4'd2, 2'b00, 1, 1, 0, 0, 0);
        run_cmd(16'h00F0, 32'h1000, 4'd2, 2'b10, 1, 1, 0, 0, 0);
        // R10 empty
        run_cmd(16'h0000, 32'h2000, 4'd3, 2'b10, 0, 1, 0, 0, 0);
        // R5 base 15
        run_cmd(16'h0006, 32'h3000, 4'd15, 2'b01, 1, 1, 0, 0, 0);
        // R6 base lowest / not lowest / no writeback
        run_cmd(16'h0038, 32'h4000, 4'd3, 2'b10, 0, 1, 0, 0, 0);
        run_cmd(16'h0038, 32'h4000, 4'd5, 2'b10, 0, 1, 0, 0, 0);
        run_cmd(16'h0038, 32'h4000, 4'd5, 2'b01, 0, 0, 0, 0, 0);
        // R7 pc store, R8 user cases
        run_cmd(16'h8001, 32'h5000, 4'd13, 2'b10, 0, 1, 1, 32'h0123_4560, 32'hA800_0003);
        run_cmd(16'h8002, 32'h6000, 4'd13, 2'b01, 1, 1, 1, 0, 0);
        run_cmd(16'h0FFF, 32'h7000, 4'd13, 2'b11, 1, 0, 1, 0, 0);
        // no stalls, full mask
        stall_pct = 0;
        run_cmd(16'hFFFF, 32'h8000, 4'd0, 2'b00, 0, 1, 0, 32'h0000_0100, 32'h4000_0002);
        stall_pct = 35;
        for (int t = 0; t < 300; t++) begin
            run_cmd(16'($urandom), $urandom, 4'($urandom), 2'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), $urandom, $urandom);
        end
        summary();
    end
endmodule